// File: doc/BRIEF.md
# Floating-Point Compare Flag Unit

This block takes two wide operand buses, compares the single-precision values held in their low 32 bits, and turns the outcome into a six-bit condition-flag register. The outcome is one of four cases: greater, less, equal or unordered. Each case maps onto a fixed pattern of the zero, parity and carry flags. The overflow, sign and auxiliary flags are cleared on every compare that completes.

A mode pin picks the NaN-signalling rule. In ordered mode any NaN raises an invalid condition. In quiet mode only a signalling NaN does. A mask pin decides what an invalid condition does. When masked, the flags take the unordered pattern and no exception is raised. When unmasked, the exception pulses and the flag register keeps its old contents.

Input is a valid/ready stream with no back-pressure: `in_ready` is tied high, so every cycle with `in_valid` high is accepted. The result is state, not a stream. `res_valid` marks the cycle in which the flags reflect a new compare, and nothing downstream can stall the block.

Top module: `fcmp_flag_unit`

## Requirements
- R1: Only bits [31:0] of `op_a` and `op_b` affect the result; the bits above are ignored.
- R2: If either operand is a NaN (exponent all ones, fraction non-zero, of either sign), the outcome is unordered. Unordered sets ZF, PF and CF to 1.
- R3: The flag bits are `flags[0]`=CF, `flags[1]`=PF and `flags[2]`=ZF. {ZF,PF,CF} is 000 when a > b, 001 when a < b and 100 when a = b.
- R4: `flags[3]`=SF, `flags[4]`=OF and `flags[5]`=AF. All three read 0 after every completed compare.
- R5: With `quiet_mode`=0, a quiet or signalling NaN in either operand is an invalid condition.
- R6: With `quiet_mode`=1, only a signalling NaN is an invalid condition. A NaN is signalling when fraction bit 22 is 0 and quiet when that bit is 1.
- R7: When an invalid condition occurs with `inv_mask`=0, `inv_exc` is 1 for that result cycle and `flags` keep their previous value.
- R8: When an invalid condition occurs with `inv_mask`=1, `flags` take the unordered pattern and `inv_exc` stays 0.
- R9: +0 and -0 compare equal. Infinities and denormals are ordered by their exact value in sign-magnitude order, with no flush to zero.
- R10: Results appear one clock after the accepting edge, with `res_valid` high in that cycle. In a cycle without `in_valid`, `flags` hold and `inv_exc` and `res_valid` are 0. Back-to-back strobes give back-to-back results.
- R11: While `rst_n` is low, `flags`, `inv_exc` and `res_valid` are all 0.
- R12: `in_ready` is always 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Compare request strobe |
| in_ready | output | 1 | Always high; no back-pressure |
| op_a | input | OP_W (128) | First operand bus, value in [31:0] |
| op_b | input | OP_W (128) | Second operand bus, value in [31:0] |
| quiet_mode | input | 1 | 1 = only signalling NaN is invalid |
| inv_mask | input | 1 | 1 = invalid condition suppressed |
| flags | output | 6 | {AF,OF,SF,ZF,PF,CF} |
| inv_exc | output | 1 | Unmasked invalid-operation pulse |
| res_valid | output | 1 | Flags updated or exception raised this cycle |

## Verification
Nearly every fault shows up at the ports in the cycle right after the strobe, because the result path has a single register stage. Examples are a mis-ordered sign-magnitude key, a wrong NaN classification or a wrong flag pattern. A fault in the hold or suppression logic is subtler: it appears as a flag value that changes when it should not. The vector sequence therefore sets up a known flag value just before each unmasked invalid compare, then checks that value survives. Idle cycles with changing operands check that nothing moves without a strobe.

// File: rtl/fcmp_pkg.sv
package fcmp_pkg;
  localparam int EXP_W  = 8;
  localparam int MAN_W  = 23;
  localparam int SP_W   = 1 + EXP_W + MAN_W;
  localparam int QBIT   = MAN_W - 1;
  localparam int FLAG_W = 6;
  localparam int FL_CF  = 0;
  localparam int FL_PF  = 1;
  localparam int FL_ZF  = 2;
  localparam int FL_SF  = 3;
  localparam int FL_OF  = 4;
  localparam int FL_AF  = 5;

  typedef enum logic [1:0] {
    CMP_GT = 2'd0,
    CMP_LT = 2'd1,
    CMP_EQ = 2'd2,
    CMP_UN = 2'd3
  } cmp_e;

  typedef struct packed {
    logic is_nan;
    logic is_snan;
    logic is_zero;
  } fp_cls_t;
endpackage

// File: rtl/fcmp_classify.sv
module fcmp_classify
  import fcmp_pkg::*;
(
  input  logic [SP_W-1:0] val,
  output fp_cls_t         cls
);
  logic [EXP_W-1:0] expo;
  logic [MAN_W-1:0] frac;

  always_comb begin
    expo        = val[SP_W-2 -: EXP_W];
    frac        = val[MAN_W-1:0];
    cls.is_nan  = (&expo) && (|frac);
    cls.is_snan = cls.is_nan && !frac[QBIT];
    cls.is_zero = ~|val[SP_W-2:0];
  end
endmodule

// File: rtl/fcmp_order.sv
module fcmp_order
  import fcmp_pkg::*;
(
  input  logic [SP_W-1:0] a,
  input  logic [SP_W-1:0] b,
  input  fp_cls_t         cls_a,
  input  fp_cls_t         cls_b,
  output cmp_e            outcome
);
  function automatic logic [SP_W-1:0] order_key(input logic [SP_W-1:0] x);
    return x[SP_W-1] ? ~x : {1'b1, x[SP_W-2:0]};
  endfunction

  logic [SP_W-1:0] ka, kb;

  always_comb begin
    ka = order_key(a);
    kb = order_key(b);
    if (cls_a.is_nan || cls_b.is_nan)       outcome = CMP_UN;
    else if (cls_a.is_zero && cls_b.is_zero) outcome = CMP_EQ;
    else if (ka == kb)                       outcome = CMP_EQ;
    else if (ka > kb)                        outcome = CMP_GT;
    else                                     outcome = CMP_LT;
  end
endmodule

// File: rtl/fcmp_flag_reg.sv
module fcmp_flag_reg
  import fcmp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              upd,
  input  cmp_e              outcome,
  input  logic              invalid,
  input  logic              mask,
  output logic [FLAG_W-1:0] flags_q,
  output logic              exc_q,
  output logic              done_q
);
  logic [2:0]        zpc;
  logic              raise;
  logic [FLAG_W-1:0] flags_d;

  always_comb begin
    unique case (outcome)
      CMP_GT:  zpc = 3'b000;
      CMP_LT:  zpc = 3'b001;
      CMP_EQ:  zpc = 3'b100;
      default: zpc = 3'b111;
    endcase
    raise          = invalid && !mask;
    flags_d        = '0;
    flags_d[FL_ZF] = zpc[2];
    flags_d[FL_PF] = zpc[1];
    flags_d[FL_CF] = zpc[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= '0;
      exc_q   <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= upd;
      exc_q  <= upd && raise;
      if (upd && !raise) flags_q <= flags_d;
    end
  end

  // R10
  hold_without_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done_q |-> $stable(flags_q));

  // R7
  exc_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exc_q |-> $stable(flags_q));

  // R10
  exc_needs_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exc_q |-> done_q);

  // R2
  parity_implies_zc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flags_q[FL_PF] |-> (flags_q[FL_ZF] && flags_q[FL_CF]));

  // R4
  upper_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q && !exc_q |-> (flags_q[FL_AF:FL_SF] == 3'b000));
endmodule

// File: rtl/fcmp_flag_unit.sv
module fcmp_flag_unit
  import fcmp_pkg::*;
#(
  parameter int OP_W = 128
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [OP_W-1:0]   op_a,
  input  logic [OP_W-1:0]   op_b,
  input  logic              quiet_mode,
  input  logic              inv_mask,
  output logic [FLAG_W-1:0] flags,
  output logic              inv_exc,
  output logic              res_valid
);
  localparam int NOPS = 2;

  logic [NOPS-1:0][SP_W-1:0] low;
  fp_cls_t [NOPS-1:0]        cls;
  cmp_e                      outcome;
  logic                      any_nan, any_snan, invalid;

  assign in_ready = 1'b1;
  assign low[0]   = op_a[SP_W-1:0];
  assign low[1]   = op_b[SP_W-1:0];

  for (genvar i = 0; i < NOPS; i++) begin : g_cls
    fcmp_classify u_cls (.val(low[i]), .cls(cls[i]));
  end

  always_comb begin
    any_nan  = cls[0].is_nan  || cls[1].is_nan;
    any_snan = cls[0].is_snan || cls[1].is_snan;
    invalid  = quiet_mode ? any_snan : any_nan;
  end

  fcmp_order u_order (
    .a(low[0]), .b(low[1]), .cls_a(cls[0]), .cls_b(cls[1]), .outcome(outcome)
  );

  fcmp_flag_reg u_freg (
    .clk(clk), .rst_n(rst_n), .upd(in_valid), .outcome(outcome),
    .invalid(invalid), .mask(inv_mask),
    .flags_q(flags), .exc_q(inv_exc), .done_q(res_valid)
  );
endmodule

// File: tb/tb_fcmp_flag_unit.sv
module tb_fcmp_flag_unit;
  localparam int OP_W = 128;
  localparam int NV   = 19;
  // {a[31:0], b[31:0], quiet, mask, zpc[2:0], exc}
  localparam logic [69:0] VEC [NV] = '{
    {32'h3F800000, 32'h40000000, 1'b0, 1'b1, 3'b001, 1'b0},
    {32'h40000000, 32'h3F800000, 1'b0, 1'b1, 3'b000, 1'b0},
    {32'h3F800000, 32'h3F800000, 1'b0, 1'b1, 3'b100, 1'b0},
    {32'hBF800000, 32'hC0000000, 1'b0, 1'b1, 3'b000, 1'b0},
    {32'hC0000000, 32'h3F800000, 1'b0, 1'b1, 3'b001, 1'b0},
    {32'h00000000, 32'h80000000, 1'b0, 1'b1, 3'b100, 1'b0},
    {32'h00000001, 32'h00000002, 1'b0, 1'b1, 3'b001, 1'b0},
    {32'h80000001, 32'h00000000, 1'b0, 1'b1, 3'b001, 1'b0},
    {32'h7F800000, 32'h40000000, 1'b0, 1'b1, 3'b000, 1'b0},
    {32'hFF800000, 32'hC0000000, 1'b0, 1'b1, 3'b001, 1'b0},
    {32'h7F800000, 32'h7F800000, 1'b0, 1'b1, 3'b100, 1'b0},
    {32'h7FC00000, 32'h3F800000, 1'b0, 1'b1, 3'b111, 1'b0},
    {32'h7FC00000, 32'h3F800000, 1'b1, 1'b0, 3'b111, 1'b0},
    {32'h7F800001, 32'h3F800000, 1'b1, 1'b1, 3'b111, 1'b0},
    {32'h3F800000, 32'h40000000, 1'b1, 1'b0, 3'b001, 1'b0},
    {32'h3F800000, 32'h7F800001, 1'b1, 1'b0, 3'b001, 1'b1},
    {32'h7FC00000, 32'h00000000, 1'b0, 1'b0, 3'b001, 1'b1},
    {32'h40000000, 32'h3F800000, 1'b0, 1'b0, 3'b000, 1'b0},
    {32'hFFC00001, 32'h80000000, 1'b0, 1'b1, 3'b111, 1'b0}
  };

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            in_valid = 1'b0;
  logic            in_ready;
  logic [OP_W-1:0] op_a = '0, op_b = '0;
  logic            quiet_mode = 1'b0, inv_mask = 1'b1;
  logic [5:0]      flags;
  logic            inv_exc, res_valid;
  int              checks = 0, fails = 0;

  always #2 clk = ~clk;

  fcmp_flag_unit #(.OP_W(OP_W)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .op_a(op_a), .op_b(op_b), .quiet_mode(quiet_mode), .inv_mask(inv_mask),
    .flags(flags), .inv_exc(inv_exc), .res_valid(res_valid)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, got, exp);
    end
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [5:0] held;
    // R11 reset state
    repeat (3) @(negedge clk);
    chk("R11", "flags in reset", 32'(flags), 0);
    chk("R11", "exc in reset", 32'(inv_exc), 0);
    chk("R11", "res_valid in reset", 32'(res_valid), 0);
    chk("R12", "in_ready", 32'(in_ready), 1);
    rst_n = 1'b1;
    @(negedge clk);

    // vector walk, back-to-back strobes (R2..R9)
    for (int i = 0; i < NV; i++) begin
      op_a       = {96'hA5A5_0000_0000_0000_0000_0000 ^ 96'(i), VEC[i][69:38]};
      op_b       = {96'h5A5A_FFFF_0000_1234_0000_0000 + 96'(i), VEC[i][37:6]};
      quiet_mode = VEC[i][5];
      inv_mask   = VEC[i][4];
      in_valid   = 1'b1;
      @(negedge clk);
      chk("R3", $sformatf("vec%0d flags", i), 32'(flags), 32'({3'b000, VEC[i][3:1]}));
      chk("R7", $sformatf("vec%0d exc", i), 32'(inv_exc), 32'(VEC[i][0]));
      chk("R10", $sformatf("vec%0d res_valid", i), 32'(res_valid), 1);
      chk("R4", $sformatf("vec%0d upper flags", i), 32'(flags[5:3]), 0);
    end
    in_valid = 1'b0;

    // R10 no strobe: flags hold, exc and res_valid low
    held = flags;
    for (int k = 0; k < 3; k++) begin
      op_a = {96'h0, 32'h3F800000};
      op_b = {96'h0, 32'h7F800001 + 32'(k)};
      quiet_mode = 1'b0; inv_mask = 1'b0;
      @(negedge clk);
      chk("R10", "idle flags hold", 32'(flags), 32'(held));
      chk("R10", "idle exc low", 32'(inv_exc), 0);
      chk("R10", "idle res_valid low", 32'(res_valid), 0);
    end

    // R1 upper bits ignored: equal low words, different high words
    op_a = {96'hFFFF_FFFF_FFFF_FFFF_FFFF_FFFF, 32'h40400000};
    op_b = {96'h0, 32'h40400000};
    quiet_mode = 1'b0; inv_mask = 1'b1; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R1", "upper bits ignored", 32'(flags), 32'h4);

    // R1 upper bits carrying a NaN pattern do not make it unordered
    op_a = {64'h0, 32'h7FC00000, 32'h3F800000};
    op_b = {64'h0, 32'h7F800001, 32'h40000000};
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R1", "upper NaN ignored", 32'(flags), 32'h1);
    chk("R5", "no exc from upper NaN", 32'(inv_exc), 0);

    // R8 masked invalid in ordered mode with negative sNaN
    op_a = {96'h0, 32'hFF800005};
    op_b = {96'h0, 32'h00000000};
    quiet_mode = 1'b0; inv_mask = 1'b1; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R8", "masked sNaN flags", 32'(flags), 32'h7);
    chk("R8", "masked sNaN exc", 32'(inv_exc), 0);

    // R6 quiet mode, unmasked qNaN: no exception, unordered written
    op_a = {96'h0, 32'h3F800000};
    op_b = {96'h0, 32'h40000000};
    in_valid = 1'b1;
    @(negedge clk);
    op_b = {96'h0, 32'hFFFFFFFF};
    quiet_mode = 1'b1; inv_mask = 1'b0;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R6", "quiet qNaN flags", 32'(flags), 32'h7);
    chk("R6", "quiet qNaN exc", 32'(inv_exc), 0);

    // R11 reset mid-run clears state
    rst_n = 1'b0;
    @(negedge clk);
    chk("R11", "flags after reset", 32'(flags), 0);
    rst_n = 1'b1;
    @(negedge clk);
    finish_run();
  end
endmodule